// File: doc/BRIEF.md
# Interrupt status and mask controller

This block holds two small registers on a CPU register bus: a status register that records which interrupt sources have fired, and a mask register that selects which of them may reach the CPU. Hardware sources raise status bits through a per-bit set vector, and a DMA request line has its own input that lands on a fixed status bit. Software clears a pending event by writing a word in which that event's bit is 0. Bits written as 1 keep their current value.

A single request line goes high while any status bit is also enabled in the mask. A one-cycle pulse marks each mask write that leaves at least one enabled event pending. Other logic can use this pulse to re-examine interrupts at once, without waiting for a new event. When a configuration input is on, one designated status bit is set just before every status write is applied. A write then keeps that bit only if the written data holds it at 1. Only the low 11 bits of each register exist, and the rest read as zero.

Top module: `isr_ctrl`

## Requirements
- R1: After reset, both registers read 0, `irq` is low and `mask_hit` is low.
- R2: A write to offset 0x070 makes the status register equal to its old value ANDed with the written data, over the written lanes. A 0 bit clears that status bit and a 1 bit leaves it unchanged.
- R3: A write to offset 0x074 stores the written data in the mask register. Register bits 31 to 11 always read as 0.
- R4: `wr_wide`=1 selects a 32-bit access and `wr_wide`=0 selects a 16-bit access. A 16-bit access uses only `wr_data[15:0]` and leaves register bits above 15 unchanged. A 16-bit write to either register acts on bits 10 to 0.
- R5: Each asserted `set_in` bit sets the matching status bit at the next clock edge. If a status write in the same cycle would clear that bit, the set still wins.
- R6: `dma_req` sets status bit 3 at the next clock edge.
- R7: While `force_en` is 1, each status write first sets status bit 9 and then applies the AND. The bit therefore ends at 1 when the data bit 9 is 1, and ends at 0 when it is 0. While `force_en` is 0, bit 9 follows R2.
- R8: `irq` is high exactly when status AND mask is nonzero. It follows the registers in the same cycle, with no extra delay.
- R9: `mask_hit` is high for the one cycle after a mask write, and only when status AND mask is nonzero after that edge.
- R10: A write to any other offset changes neither register. A read from any other offset returns 0. `rd_data` shows the register that `rd_addr` selects, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| wr_addr | input | 12 | Write offset within the I/O page |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read offset within the I/O page |
| rd_data | output | 32 | Read data for `rd_addr` |
| set_in | input | 11 | Per-bit status set requests |
| dma_req | input | 1 | DMA interrupt request, sets status bit 3 |
| force_en | input | 1 | Enables setting bit 9 before each status write |
| irq | output | 1 | Pending, unmasked interrupt present |
| mask_hit | output | 1 | Pulse after a mask write that leaves an enabled event pending |

## Verification
Several properties are checked on every cycle:
- a status write with no set request and no forcing never raises a bit;
- a set request always lands;
- status holds steady when nothing touches it;
- a 32-bit mask write stores its data;
- a rising `irq` always has a cause;
- `mask_hit` implies `irq`.

Some behaviour can only be shown by the bench's scenarios against its reference model:
- the exact AND result of an acknowledge;
- the interplay of `force_en` with data bit 9;
- 16-bit lane handling;
- the value returned from a read of an unused offset.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic {ACC_HALF = 1'b0, ACC_WORD = 1'b1} acc_size_e;
  localparam int HALF_BITS = 16;
endpackage

// File: rtl/isr_decode.sv
module isr_decode #(
  parameter int NB       = 11,
  parameter int AW       = 12,
  parameter logic [AW-1:0] STAT_OFS = 12'h070,
  parameter logic [AW-1:0] MASK_OFS = 12'h074
) (
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [AW-1:0] wr_addr,
  output logic          st_wr,
  output logic          mk_wr,
  output logic [NB-1:0] lanes
);
  import isr_pkg::*;

  function automatic logic [NB-1:0] lane_bits(input logic wide);
    logic [NB-1:0] l;
    for (int i = 0; i < NB; i++) l[i] = (i < HALF_BITS) || (wide == ACC_WORD);
    return l;
  endfunction

  assign st_wr = wr_en && (wr_addr == STAT_OFS);
  assign mk_wr = wr_en && (wr_addr == MASK_OFS);
  assign lanes = lane_bits(wr_wide);
endmodule

// File: rtl/isr_status.sv
module isr_status #(
  parameter int NB        = 11,
  parameter int FORCE_BIT = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_wr,
  input  logic [NB-1:0] lanes,
  input  logic [NB-1:0] data,
  input  logic          force_en,
  input  logic [NB-1:0] set_vec,
  output logic [NB-1:0] st_d,
  output logic [NB-1:0] st_q
);
  logic [NB-1:0] frc;

  generate
    if (FORCE_BIT < NB) begin : g_force
      localparam logic [NB-1:0] FORCE_ONE = NB'(1) << FORCE_BIT;
      assign frc = force_en ? FORCE_ONE : '0;
    end else begin : g_noforce
      assign frc = '0;
    end
  endgenerate

  function automatic logic [NB-1:0] ack_merge(input logic [NB-1:0] old,
      input logic [NB-1:0] d, input logic [NB-1:0] ln, input logic [NB-1:0] f);
    return (old | f) & (d | ~ln);
  endfunction

  always_comb begin
    st_d = st_q;
    if (st_wr) st_d = ack_merge(st_q, data, lanes, frc);
    st_d = st_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
endmodule

// File: rtl/isr_mask.sv
module isr_mask #(
  parameter int NB = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mk_wr,
  input  logic [NB-1:0] lanes,
  input  logic [NB-1:0] data,
  output logic [NB-1:0] mk_d,
  output logic [NB-1:0] mk_q
);
  function automatic logic [NB-1:0] mask_merge(input logic [NB-1:0] old,
      input logic [NB-1:0] d, input logic [NB-1:0] ln);
    return (old & ~ln) | (d & ln);
  endfunction

  assign mk_d = mk_wr ? mask_merge(mk_q, data, lanes) : mk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mk_q <= '0;
    else        mk_q <= mk_d;
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl #(
  parameter int NB        = 11,
  parameter int AW        = 12,
  parameter int FORCE_BIT = 9,
  parameter int DMA_BIT   = 3,
  parameter logic [AW-1:0] STAT_OFS = 12'h070,
  parameter logic [AW-1:0] MASK_OFS = 12'h074
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic [NB-1:0] set_in,
  input  logic          dma_req,
  input  logic          force_en,
  output logic          irq,
  output logic          mask_hit
);
  localparam logic [NB-1:0] DMA_ONE = NB'(1) << DMA_BIT;

  logic          st_wr, mk_wr;
  logic [NB-1:0] lanes, data_n, set_vec;
  logic [NB-1:0] st_d, st_q, mk_d, mk_q;
  logic          hit_q;

  assign data_n  = wr_data[NB-1:0];
  assign set_vec = set_in | (dma_req ? DMA_ONE : '0);

  generate
    if (NB < 32) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wr_data[31:NB];
    end
  endgenerate

  isr_decode #(.NB(NB), .AW(AW), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
    .st_wr(st_wr), .mk_wr(mk_wr), .lanes(lanes));

  isr_status #(.NB(NB), .FORCE_BIT(FORCE_BIT)) u_st (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .lanes(lanes), .data(data_n),
    .force_en(force_en), .set_vec(set_vec), .st_d(st_d), .st_q(st_q));

  isr_mask #(.NB(NB)) u_mk (
    .clk(clk), .rst_n(rst_n), .mk_wr(mk_wr), .lanes(lanes), .data(data_n),
    .mk_d(mk_d), .mk_q(mk_q));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= mk_wr && (|(st_d & mk_d));

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_OFS)      rd_data[NB-1:0] = st_q;
    else if (rd_addr == MASK_OFS) rd_data[NB-1:0] = mk_q;
  end

  assign irq      = |(st_q & mk_q);
  assign mask_hit = hit_q;
endmodule

// File: rtl/isr_ctrl_chk.sv
module isr_ctrl_chk #(
  parameter int NB        = 11,
  parameter int FORCE_BIT = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_wr,
  input logic          mk_wr,
  input logic          wr_wide,
  input logic          force_en,
  input logic [NB-1:0] data_n,
  input logic [NB-1:0] set_vec,
  input logic [NB-1:0] st_q,
  input logic [NB-1:0] mk_q,
  input logic          irq,
  input logic          mask_hit
);
  p_ack_no_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !force_en && set_vec == '0) |=> ((st_q & ~$past(st_q)) == '0));

  p_mask_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_wr && wr_wide) |=> (mk_q == $past(data_n)));

  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((st_q & $past(set_vec)) == $past(set_vec)));

  p_force_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && force_en && data_n[FORCE_BIT]) |=> st_q[FORCE_BIT]);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mk_wr || (set_vec != '0) || (st_wr && force_en)));

  p_hit_implies_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hit |-> irq);

  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && set_vec == '0) |=> $stable(st_q));
endmodule

bind isr_ctrl isr_ctrl_chk #(.NB(NB), .FORCE_BIT(FORCE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .mk_wr(mk_wr), .wr_wide(wr_wide),
  .force_en(force_en), .data_n(data_n), .set_vec(set_vec), .st_q(st_q),
  .mk_q(mk_q), .irq(irq), .mask_hit(mask_hit));

// File: tb/sim_isr_ctrl.sv
module sim_isr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, dma_req = 1'b0, force_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [10:0] set_in = '0;
  logic [31:0] rd_data;
  logic        irq, mask_hit;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [10:0] m_st = '0, m_mk = '0;
  logic        m_hit = 1'b0;

  always #4 clk = ~clk;

  isr_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .set_in(set_in), .dma_req(dma_req), .force_en(force_en), .irq(irq),
    .mask_hit(mask_hit));

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a == 12'h070) return {21'd0, m_st};
    if (a == 12'h074) return {21'd0, m_mk};
    return 32'd0;
  endfunction

  task automatic compare(input string tag);
    check(tag, "rd_data", rd_data, exp_read(rd_addr));
    check(tag, "irq", {31'd0, irq}, {31'd0, (m_st & m_mk) != 0});
    check(tag, "mask_hit", {31'd0, mask_hit}, {31'd0, m_hit});
  endtask

  // one bus cycle: drive after a falling edge, update the model at the rising edge
  task automatic step(input string tag, input logic we, input logic wide,
      input logic [11:0] wa, input logic [31:0] wd, input logic [10:0] s,
      input logic dma, input logic frc, input logic [11:0] ra);
    logic [10:0] ns, nm;
    wr_en = we; wr_wide = wide; wr_addr = wa; wr_data = wd;
    set_in = s; dma_req = dma; force_en = frc; rd_addr = ra;
    @(posedge clk);
    ns = m_st; nm = m_mk;
    if (we && wa == 12'h070) begin
      if (frc) ns[9] = 1'b1;
      for (int b = 0; b < 11; b++) if (wd[b] == 1'b0) ns[b] = 1'b0;
    end
    if (we && wa == 12'h074)
      for (int b = 0; b < 11; b++) nm[b] = wd[b];
    for (int b = 0; b < 11; b++) if (s[b]) ns[b] = 1'b1;
    if (dma) ns[3] = 1'b1;
    m_hit = we && (wa == 12'h074) && ((ns & nm) != 0);
    m_st = ns; m_mk = nm;
    @(negedge clk);
    wr_en = 1'b0; set_in = '0; dma_req = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input string tag, input logic [11:0] ra);
    step(tag, 1'b0, 1'b1, 12'h0, 32'h0, '0, 1'b0, 1'b0, ra);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_addr = 12'h070; #1 compare("R1");
    rd_addr = 12'h074; #1 compare("R1");
    // R3 32-bit mask write, upper bits read 0
    step("R3", 1, 1, 12'h074, 32'hFFFF_FFFF, '0, 0, 0, 12'h074);
    // R5 set inputs raise status, R8 irq follows
    step("R5", 0, 1, 12'h0, 32'h0, 11'h005, 0, 0, 12'h070);
    idle("R8", 12'h070);
    // R2 acknowledge bit 0 only
    step("R2", 1, 1, 12'h070, 32'hFFFF_FFFE, '0, 0, 0, 12'h070);
    // R5 set wins over a clearing write of the same bit
    step("R5", 1, 1, 12'h070, 32'h0, 11'h004, 0, 0, 12'h070);
    // R6 DMA request lands on bit 3
    step("R6", 0, 1, 12'h0, 32'h0, '0, 1, 0, 12'h070);
    // R7 forced bit 9 with data bit 9 set survives
    step("R7", 1, 1, 12'h070, 32'hFFFF_FFFF, '0, 0, 1, 12'h070);
    // R7 forced bit 9 cleared when data bit 9 is 0
    step("R7", 1, 1, 12'h070, 32'hFFFF_FDFF, '0, 0, 1, 12'h070);
    // R7 without forcing, writing 1 does not raise bit 9
    step("R7", 1, 1, 12'h070, 32'hFFFF_FFFF, '0, 0, 0, 12'h070);
    // R2 clear everything
    step("R2", 1, 1, 12'h070, 32'h0, '0, 0, 0, 12'h070);
    // R9 mask write with nothing pending: no pulse
    step("R9", 1, 1, 12'h074, 32'h0000_0010, '0, 0, 0, 12'h074);
    step("R5", 0, 1, 12'h0, 32'h0, 11'h020, 0, 0, 12'h070);
    // R9 mask write that enables a pending bit: one-cycle pulse
    step("R9", 1, 1, 12'h074, 32'h0000_0020, '0, 0, 0, 12'h074);
    idle("R9", 12'h074);
    // R4 16-bit mask write ignores upper data bits
    step("R4", 1, 0, 12'h074, 32'hABCD_0481, '0, 0, 0, 12'h074);
    // R4 16-bit status acknowledge
    step("R5", 0, 1, 12'h0, 32'h0, 11'h7FF, 0, 0, 12'h070);
    step("R4", 1, 0, 12'h070, 32'h0000_FF7E, '0, 0, 0, 12'h070);
    // R10 writes elsewhere change nothing, reads elsewhere return 0
    step("R10", 1, 1, 12'h078, 32'h0, '0, 0, 0, 12'h070);
    step("R10", 1, 1, 12'h170, 32'h0, '0, 0, 0, 12'h074);
    idle("R10", 12'h078);
    idle("R10", 12'h000);
    // R8 mask cleared drops irq
    step("R8", 1, 1, 12'h074, 32'h0, '0, 0, 0, 12'h070);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule